// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver

This block receives asynchronous serial characters on a line shared by several stations. Every character carries one extra bit after its data bits. That bit tells whether the character names a station (an ID character, bit = 1) or carries payload (bit = 0). The line is oversampled by a baud tick at 16 times the bit rate. Each bit is taken at its middle and shifted into a frame assembler, which hands complete characters to a small register file.

Firmware can put the receiver to sleep by setting a wake-up enable. While it sleeps, payload characters are dropped silently. The data register, the receive-full flag and both error flags stay as they are. When the next ID character arrives, hardware clears the enable and accepts that character as a normal one. Firmware can then compare the ID with its own and either stay awake or go back to sleep. A parity-select control bit is stored, but it has no effect, because this frame format has no parity bit.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one start bit (0), 8 data bits sent LSB first, one station bit and one stop bit, each lasting 16 baud ticks. An accepted character is placed on `rx_data`, can be read at address 2, and sets status bit 0 (full).
- R2: Every accepted character copies its station bit into status bit 3. This bit is 1 after an ID character and 0 after a data character.
- R3: While control bit 1 (wake-up enable) is 1, a character whose station bit is 0 changes neither `rx_data` nor any status bit, and control bit 1 stays at 1.
- R4: While control bit 1 is 1, a character whose station bit is 1 clears control bit 1, sets status bit 3 and is accepted as in R1.
- R5: `rx_irq` is high exactly while control bit 0 (interrupt enable) and status bit 0 are both 1.
- R6: An accepted character whose stop bit is sampled as 0 sets status bit 1 (framing error), and its data is still stored. No framing error is raised while the receiver is asleep. After a 0 stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R7: A character that completes while status bit 0 is 1 sets status bit 2 (overrun) and leaves `rx_data` unchanged.
- R8: A read at address 2 returns the data byte and clears status bit 0.
- R9: Writing status (address 1) clears bit 1 or bit 2 wherever the written bit is 0. Writing 1 never sets them. Bits 0 and 3 are read-only.
- R10: Control bit 2 (parity select) reads back as written and does not change the frame length or content.
- R11: A low pulse on the line that is shorter than half a bit is ignored as a start bit.
- R12: After reset, control and status read as 0, `rx_data` is 0 and `rx_irq` is low. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line (idle high) |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at address 2) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rx_data | output | 8 | Current receive data register |
| rx_irq | output | 1 | Receive interrupt (level) |

## Verification
The checker watches the internal hand-off between the frame assembler and the register file on every cycle. It checks these properties:
- A sleeping receiver holds its data and flags when a payload character arrives.
- An ID character wakes the receiver and sets the station flag.
- An overrun keeps the old byte.
- A 0 stop bit raises the framing error.
- A data read empties the register.

Only the bench scenarios can show the things that depend on real serial timing: correct bit order and mid-bit sampling, glitch rejection, the line-high wait after a bad stop bit, interrupt behaviour as seen from the port, and the read-back of the ignored parity bit.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_BITS,
        FS_STOP,
        FS_WAIT_HI
    } frm_state_e;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              tick,
    output logic              done,
    output logic [DATA_W-1:0] char_data,
    output logic              char_mpb,
    output logic              stop_ok
);
    localparam int NBITS = DATA_W + 1;
    localparam int CW    = $clog2(OSR);
    localparam int BW    = $clog2(NBITS + 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

    typedef struct packed {
        frm_state_e       st;
        logic [CW-1:0]    cnt;
        logic [BW-1:0]    nb;
        logic [NBITS-1:0] sh;
        logic             done;
        logic             stop_ok;
    } frm_t;

    frm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick) begin
            unique case (q.st)
                FS_IDLE: begin
                    if (!rx) begin
                        d.st  = FS_START;
                        d.cnt = '0;
                    end
                end
                FS_START: begin
                    if (q.cnt == HALF_CNT) begin
                        d.cnt = '0;
                        d.nb  = '0;
                        d.st  = rx ? FS_IDLE : FS_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FS_BITS: begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt = '0;
                        d.sh  = {rx, q.sh[NBITS-1:1]};
                        if (q.nb == LAST_BIT) d.st = FS_STOP;
                        else                  d.nb = q.nb + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FS_STOP: begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt     = '0;
                        d.done    = 1'b1;
                        d.stop_ok = rx;
                        d.st      = rx ? FS_IDLE : FS_WAIT_HI;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FS_WAIT_HI: begin
                    if (rx) d.st = FS_IDLE;
                end
                default: d.st = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= FS_IDLE;
            q.stop_ok <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign char_data = q.sh[DATA_W-1:0];
    assign char_mpb  = q.sh[NBITS-1];
    assign stop_ok   = q.stop_ok;
endmodule

// File: rtl/mpr_regs.sv
module mpr_regs
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_mpb,
    input  logic              stop_ok,
    output logic [DATA_W-1:0] data_out,
    output logic              irq,
    output logic              wake_out,
    output logic              full_out,
    output logic              ferr_out,
    output logic              ovr_out,
    output logic              mpb_out
);
    typedef struct packed {
        logic              irq_en;
        logic              wake;
        logic              par_sel;
        logic              full;
        logic              ferr;
        logic              ovr;
        logic              mpb;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t q, d;
    logic  data_read;
    logic  accept;

    always_comb begin
        d         = q;
        data_read = reg_rd && (reg_addr == ADDR_DATA);
        accept    = done && (!q.wake || char_mpb);

        if (data_read) d.full = 1'b0;

        if (reg_wr) begin
            unique case (reg_addr)
                ADDR_CTRL: begin
                    d.irq_en  = reg_wdata[0];
                    d.wake    = reg_wdata[1];
                    d.par_sel = reg_wdata[2];
                end
                ADDR_STAT: begin
                    d.ferr = q.ferr & reg_wdata[1];
                    d.ovr  = q.ovr  & reg_wdata[2];
                end
                default: ;
            endcase
        end

        if (done && q.wake && char_mpb) d.wake = 1'b0;

        if (accept) begin
            d.mpb = char_mpb;
            if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = char_data;
                d.full = 1'b1;
            end
            if (!stop_ok) d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata[2:0] = {q.par_sel, q.wake, q.irq_en};
            ADDR_STAT: reg_rdata[3:0] = {q.mpb, q.ovr, q.ferr, q.full};
            ADDR_DATA: reg_rdata      = q.data;
            default:   reg_rdata      = '0;
        endcase
    end

    assign data_out = q.data;
    assign irq      = q.irq_en & q.full;
    assign wake_out = q.wake;
    assign full_out = q.full;
    assign ferr_out = q.ferr;
    assign ovr_out  = q.ovr;
    assign mpb_out  = q.mpb;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq
);
    logic              rx_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mpb;
    logic              frm_stop_ok;
    logic              wake_st;
    logic              full_st;
    logic              ferr_st;
    logic              ovr_st;
    logic              mpb_st;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    mpr_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx_s),
        .tick     (baud_tick),
        .done     (frm_done),
        .char_data(frm_data),
        .char_mpb (frm_mpb),
        .stop_ok  (frm_stop_ok)
    );

    mpr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .done     (frm_done),
        .char_data(frm_data),
        .char_mpb (frm_mpb),
        .stop_ok  (frm_stop_ok),
        .data_out (rx_data),
        .irq      (rx_irq),
        .wake_out (wake_st),
        .full_out (full_st),
        .ferr_out (ferr_st),
        .ovr_out  (ovr_st),
        .mpb_out  (mpb_st)
    );
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic              frm_done,
    input logic              frm_mpb,
    input logic              frm_stop_ok,
    input logic              wake_st,
    input logic              full_st,
    input logic              ferr_st,
    input logic              ovr_st,
    input logic              mpb_st,
    input logic [DATA_W-1:0] rx_data
);
    p_sleep_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_st && frm_done && !frm_mpb && !reg_wr && !reg_rd)
        |=> ($stable(rx_data) && $stable(full_st) && $stable(ferr_st)
             && $stable(ovr_st) && $stable(mpb_st) && wake_st));

    p_id_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_st && frm_done && frm_mpb) |=> (!wake_st && mpb_st && full_st));

    p_bad_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_st && frm_done && !frm_stop_ok) |=> ferr_st);

    p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_st && frm_done && full_st && !(reg_rd && reg_addr == ADDR_DATA))
        |=> (ovr_st && $stable(rx_data)));

    p_read_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_DATA && !frm_done) |=> !full_st);
endmodule

bind mp_uart_rx mpr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .frm_done   (frm_done),
    .frm_mpb    (frm_mpb),
    .frm_stop_ok(frm_stop_ok),
    .wake_st    (wake_st),
    .full_st    (full_st),
    .ferr_st    (ferr_st),
    .ovr_st     (ovr_st),
    .mpb_st     (mpb_st),
    .rx_data    (rx_data)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] rx_data;
    logic       rx_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    mp_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_data(rx_data), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt  <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == TICK_DIV - 1);
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold_line(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic mpb, input logic stop);
        @(negedge clk);
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold_line(b[i], BIT_CLKS);
        hold_line(mpb, BIT_CLKS);
        hold_line(stop, BIT_CLKS);
        hold_line(1'b1, BIT_CLKS);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R12 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R12 status", v, 8'h00);
        rd(2'd3, v); chk("R12 addr3", v, 8'h00);
        chk("R12 rx_data", rx_data, 8'h00);
        chk("R12 irq", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        send(8'hA5, 1'b0, 1'b1);
        rd(2'd1, v); chk("R1 full, R2 mpb0", v, 8'h01);
        chk("R1 rx_data", rx_data, 8'hA5);
        rd(2'd2, v); chk("R8 data read", v, 8'hA5);
        rd(2'd1, v); chk("R8 full cleared", v, 8'h00);
        send(8'h3C, 1'b1, 1'b1);
        rd(2'd1, v); chk("R2 mpb1", v, 8'h09);
        rd(2'd2, v); chk("R1 id byte", v, 8'h3C);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd0, 8'h01);
        chk("R5 irq idle", {7'd0, rx_irq}, 8'h00);
        send(8'h11, 1'b0, 1'b1);
        chk("R5 irq set", {7'd0, rx_irq}, 8'h01);
        rd(2'd2, v);
        chk("R5 irq cleared", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_wake();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        send(8'h22, 1'b0, 1'b1);
        rd(2'd1, v); chk("R3 status held", v, 8'h00);
        chk("R3 data held", rx_data, 8'h11);
        rd(2'd0, v); chk("R3 still asleep", v, 8'h03);
        send(8'h33, 1'b0, 1'b0);
        rd(2'd1, v); chk("R6 no ferr asleep", v, 8'h00);
        send(8'h44, 1'b1, 1'b1);
        rd(2'd0, v); chk("R4 wake cleared", v, 8'h01);
        rd(2'd1, v); chk("R4 status", v, 8'h09);
        chk("R4 data", rx_data, 8'h44);
        chk("R4 irq", {7'd0, rx_irq}, 8'h01);
        rd(2'd2, v);
        send(8'h55, 1'b0, 1'b1);
        rd(2'd1, v); chk("R2 normal after wake", v, 8'h01);
        rd(2'd2, v); chk("R4 resumed data", v, 8'h55);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send(8'h66, 1'b0, 1'b1);
        send(8'h77, 1'b1, 1'b1);
        rd(2'd1, v); chk("R7 ovr flag", v & 8'h07, 8'h05);
        chk("R7 data kept", rx_data, 8'h66);
        rd(2'd2, v);
        rd(2'd1, v); chk("R8 ovr stays", v & 8'h07, 8'h04);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R9 ovr cleared", v & 8'h07, 8'h00);
        wr(2'd1, 8'h0F);
        rd(2'd1, v); chk("R9 write 1 no set", v & 8'h07, 8'h00);
    endtask

    task automatic t_ferr();
        logic [7:0] v;
        send(8'h0F, 1'b0, 1'b0);
        rd(2'd1, v); chk("R6 ferr", v, 8'h03);
        chk("R6 data stored", rx_data, 8'h0F);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R9 ferr cleared", v, 8'h01);
        rd(2'd2, v);
        send(8'hC3, 1'b0, 1'b1);
        rd(2'd2, v); chk("R6 next frame ok", v, 8'hC3);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk("R10 readback", v, 8'h04);
        send(8'h81, 1'b1, 1'b1);
        rd(2'd1, v); chk("R10 status", v, 8'h09);
        rd(2'd2, v); chk("R10 data", v, 8'h81);
        send(8'h18, 1'b0, 1'b1);
        rd(2'd2, v); chk("R10 second", v, 8'h18);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk);
        hold_line(1'b0, 3 * TICK_DIV);
        hold_line(1'b1, 2 * BIT_CLKS);
        rd(2'd1, v); chk("R11 glitch ignored", v, 8'h00);
        send(8'h99, 1'b0, 1'b1);
        rd(2'd2, v); chk("R11 alive after", v, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_irq();
        t_wake();
        t_overrun();
        t_ferr();
        t_parity();
        t_glitch();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule